// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the host-facing configuration front end of a multi-function I/O device. It sits on an 8-bit I/O bus behind a two-address window. Address bit 0 picks the port: 0 is the index (register pointer) port and 1 is the data port. Nothing can be read or changed until the host writes a two-step unlock key to the index port. While unlocked, the host points the index at a register and then reads or writes that register through the data port. A further key value locks the block again.

Register numbers below 0x30 reach a global bank of 48 bytes. Global register 0x07 holds a logical device number, and register numbers 0x30 and above reach that device's own bank. Each device bank stores eight registers: activate (0x30), base address high and low (0x60, 0x61), resource registers 0x70 and 0x74, and mode registers 0xF0, 0xF1 and 0xF2. Write protection depends on the device number, on the register number and on the chip identifier, which is set by a parameter. Each device's activate bit and 16-bit base address are driven out continuously so that the address decoders further along can use them.

The key sequence is handled by a three-state machine. The states are `ST_LOCKED`, `ST_KEY_SEEN` and `ST_OPEN`. The transitions are:
- `ST_LOCKED` to `ST_KEY_SEEN` on an index write of 0x55.
- `ST_KEY_SEEN` to `ST_OPEN` on a second index write of 0x55.
- `ST_KEY_SEEN` back to `ST_LOCKED` on an index write of any other value.
- `ST_OPEN` to `ST_LOCKED` on an index write of 0xAA.
- `ST_OPEN` stays in `ST_OPEN` on any other index write, which loads the index register.

Top module: `cfg_port_ctrl`

## Requirements
- R1: `bus_addr`=0 selects the index port and `bus_addr`=1 selects the data port. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational and has no read side effects.
- R2: The block unlocks only after two index writes of 0x55 in a row. An index write of any other value between them restarts the count. Data-port writes do not affect the count.
- R3: While unlocked, an index write of 0xAA locks the block. Any other index value is stored as the current register number and reads back at the index port.
- R4: While locked, both ports read 0xFF and data-port writes change no register.
- R5: Global registers 0x00 to 0x2F are readable and writable. Global register 0x07 selects the device bank used for register numbers 0x30 and above.
- R6: Device-bank writes are dropped for devices 1, 2, 6 and 7, and for device numbers of 10 and above.
- R7: For devices 0 to 3, writes to registers 0x70 to 0x7F are dropped.
- R8: Global register 0x20 (chip ID, equal to parameter `VARIANT_ID`) and global register 0x21 (revision, 0x01) are read-only.
- R9: Device 9 accepts writes only when the chip ID is 0x03.
- R10: After reset the block is locked. Global registers 0x03=0x03, 0x24=0x04, 0x26=0xF0 and 0x27=0x03, and all other global registers are 0 except 0x20 and 0x21. Device 0 resets to activate=1, base=0x03F0, 0x70=0x06, 0x74=0x02, 0xF0=0x0E and 0xF2=0xFF.
- R11: Device registers other than 0x30, 0x60, 0x61, 0x70, 0x74, 0xF0, 0xF1 and 0xF2 read as 0x00, and writes to them have no effect.
- R12: `dev_active[d]` is bit 0 of device d's register 0x30. `dev_base[16*d +: 16]` is {register 0x60, register 0x61}. Both outputs change on the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Port select: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by `bus_addr` |
| cfg_open | output | 1 | High while the block is unlocked |
| dev_active | output | NDEV | Activate bit of each device |
| dev_base | output | 16*NDEV | Base address of each device, 16 bits per device |

## Verification
The hardest behaviour to reach from the ports is the device 9 gate on the chip ID. The ID register is read-only, so no write sequence can change it. The bench therefore drives a second instance, built with a different `VARIANT_ID`, from the same bus signals. It compares that instance's device 9 activate bit with the default instance's after an identical write. The write masks on the other devices are checked at the ports in the same way: the bench writes a changed value, then reads the register back or watches `dev_base` and `dev_active`.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_KEY_SEEN,
        ST_OPEN
    } key_state_e;

    localparam logic [7:0] KEY_ENTER   = 8'h55;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam int         GLB_SIZE    = 48;
    localparam logic [7:0] GLB_LIMIT   = 8'h30;
    localparam int         IDX_DEVSEL  = 7;
    localparam int         IDX_CHIP    = 32;
    localparam int         IDX_REV     = 33;
    localparam int         NSLOT       = 8;
    localparam int         SLOT_W      = $clog2(NSLOT);

    // Map a device register number to its storage slot; bit SLOT_W flags a hit.
    function automatic logic [SLOT_W:0] slot_of(input logic [7:0] idx);
        logic [SLOT_W:0] r;
        unique case (idx)
            8'h30:   r = {1'b1, 3'd0};
            8'h60:   r = {1'b1, 3'd1};
            8'h61:   r = {1'b1, 3'd2};
            8'h70:   r = {1'b1, 3'd3};
            8'h74:   r = {1'b1, 3'd4};
            8'hF0:   r = {1'b1, 3'd5};
            8'hF1:   r = {1'b1, 3'd6};
            8'hF2:   r = {1'b1, 3'd7};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] glb_default(input int i, input logic [7:0] chip);
        logic [7:0] v;
        case (i)
            3:       v = 8'h03;
            32:      v = chip;
            33:      v = 8'h01;
            36:      v = 8'h04;
            38:      v = 8'hF0;
            39:      v = 8'h03;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Reset value of slot s of device d.
    function automatic logic [7:0] dev_default(input int d, input int s);
        logic [7:0] v;
        v = 8'h00;
        case (d)
            0: case (s)
                0: v = 8'h01; 1: v = 8'h03; 2: v = 8'hF0; 3: v = 8'h06;
                4: v = 8'h02; 5: v = 8'h0E; 7: v = 8'hFF; default: v = 8'h00;
            endcase
            1: case (s)
                1: v = 8'h01; 2: v = 8'hF0; 3: v = 8'h0E; 5: v = 8'h0C;
                default: v = 8'h00;
            endcase
            2: case (s)
                1: v = 8'h01; 2: v = 8'h70; 3: v = 8'h0F; default: v = 8'h00;
            endcase
            3: case (s)
                0: v = 8'h01; 1: v = 8'h03; 2: v = 8'h78; 3: v = 8'h07;
                4: v = 8'h04; 5: v = 8'h3C; default: v = 8'h00;
            endcase
            4: case (s)
                0: v = 8'h01; 1: v = 8'h03; 2: v = 8'hF8; 3: v = 8'h04;
                5: v = 8'h03; default: v = 8'h00;
            endcase
            5: case (s)
                0: v = 8'h01; 1: v = 8'h02; 2: v = 8'hF8; 3: v = 8'h03;
                4: v = 8'h04; 6: v = 8'h02; 7: v = 8'h03; default: v = 8'h00;
            endcase
            7: case (s)
                0: v = 8'h01; 2: v = 8'h60; 3: v = 8'h01; default: v = 8'h00;
            endcase
            8: case (s)
                0: v = 8'h01; 2: v = 8'hEA; default: v = 8'h00;
            endcase
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Write permission for a device-bank register.
    function automatic logic dev_write_ok(input logic [7:0] dev, input logic [7:0] idx,
                                          input logic [7:0] chip);
        logic ok;
        ok = 1'b1;
        if (dev == 8'd1 || dev == 8'd2)                  ok = 1'b0;
        if (dev > 8'd5 && dev != 8'd8 && dev != 8'd9)    ok = 1'b0;
        if (dev < 8'd4 && idx[7:4] == 4'h7)              ok = 1'b0;
        if (dev == 8'd9 && chip != 8'h03)                ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       idx_load
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_ENTER) begin
                    state_d = ST_KEY_SEEN;
                end
            end
            ST_KEY_SEEN: begin
                if (idx_wr) begin
                    state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
                end
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_EXIT) begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = 1'b0;
        idx_load = 1'b0;
        unique case (state_q)
            ST_LOCKED:   ;
            ST_KEY_SEEN: ;
            ST_OPEN: begin
                cfg_open = 1'b1;
                idx_load = idx_wr && (wdata != KEY_EXIT);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_glb_bank.sv
module cfg_glb_bank
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] VARIANT_ID = 8'h03
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [5:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] dev_sel,
    output logic [7:0] chip_id
);

    localparam int AW = $clog2(GLB_SIZE);

    logic [7:0] regs [GLB_SIZE];
    logic       ro_hit;

    assign ro_hit = (int'(addr) == IDX_CHIP) || (int'(addr) == IDX_REV);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLB_SIZE; i++) begin
                regs[i] <= glb_default(i, VARIANT_ID);
            end
        end else if (we && !ro_hit && int'(addr) < GLB_SIZE) begin
            regs[addr[AW-1:0]] <= wdata;
        end
    end

    assign rdata   = (int'(addr) < GLB_SIZE) ? regs[addr[AW-1:0]] : 8'h00;
    assign dev_sel = regs[IDX_DEVSEL];
    assign chip_id = regs[IDX_CHIP];

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_port_pkg::*;
#(
    parameter int NDEV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        dev_sel,
    input  logic [7:0]        reg_idx,
    input  logic [7:0]        wdata,
    input  logic [7:0]        chip_id,
    output logic [7:0]        rdata,
    output logic [NDEV-1:0]   dev_active,
    output logic [NDEV*16-1:0] dev_base
);

    logic [SLOT_W:0]   slot_hit;
    logic [SLOT_W-1:0] slot;
    logic              hit;
    logic              allow;
    logic [7:0]        dev_rd [NDEV];

    assign slot_hit = slot_of(reg_idx);
    assign hit      = slot_hit[SLOT_W];
    assign slot     = slot_hit[SLOT_W-1:0];
    assign allow    = we && hit && dev_write_ok(dev_sel, reg_idx, chip_id);

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        logic [7:0] regs [NSLOT];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NSLOT; s++) begin
                    regs[s] <= dev_default(g, s);
                end
            end else if (allow && dev_sel == 8'(g)) begin
                regs[slot] <= wdata;
            end
        end

        assign dev_rd[g]              = hit ? regs[slot] : 8'h00;
        assign dev_active[g]          = regs[0][0];
        assign dev_base[g*16 +: 16]   = {regs[1], regs[2]};
    end

    always_comb begin
        rdata = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (dev_sel == 8'(d)) begin
                rdata = dev_rd[d];
            end
        end
    end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int         NDEV       = 10,
    parameter logic [7:0] VARIANT_ID = 8'h03
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_addr,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               cfg_open,
    output logic [NDEV-1:0]    dev_active,
    output logic [NDEV*16-1:0] dev_base
);

    logic       idx_wr;
    logic       dat_wr;
    logic       idx_load;
    logic [7:0] idx_q;
    logic       glb_space;
    logic [7:0] glb_rd;
    logic [7:0] dev_rd;
    logic [7:0] dev_sel;
    logic [7:0] chip_id;

    assign idx_wr    = bus_wr && !bus_addr;
    assign dat_wr    = bus_wr && bus_addr && cfg_open;
    assign glb_space = idx_q < GLB_LIMIT;

    cfg_key_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
        end else if (idx_load) begin
            idx_q <= bus_wdata;
        end
    end

    cfg_glb_bank #(.VARIANT_ID(VARIANT_ID)) u_glb (
        .clk     (clk),
        .rst     (rst),
        .we      (dat_wr && glb_space),
        .addr    (idx_q[5:0]),
        .wdata   (bus_wdata),
        .rdata   (glb_rd),
        .dev_sel (dev_sel),
        .chip_id (chip_id)
    );

    cfg_dev_bank #(.NDEV(NDEV)) u_dev (
        .clk        (clk),
        .rst        (rst),
        .we         (dat_wr && !glb_space),
        .dev_sel    (dev_sel),
        .reg_idx    (idx_q),
        .wdata      (bus_wdata),
        .chip_id    (chip_id),
        .rdata      (dev_rd),
        .dev_active (dev_active),
        .dev_base   (dev_base)
    );

    always_comb begin
        if (!cfg_open) begin
            bus_rdata = 8'hFF;
        end else if (!bus_addr) begin
            bus_rdata = idx_q;
        end else if (glb_space) begin
            bus_rdata = glb_rd;
        end else begin
            bus_rdata = dev_rd;
        end
    end

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int NDEV = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_addr,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               cfg_open,
    input logic [NDEV-1:0]    dev_active,
    input logic [NDEV*16-1:0] dev_base,
    input logic [7:0]         idx_q,
    input logic [7:0]         chip_id
);

    AST_ENTER_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h55)); // R2

    AST_EXIT_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open); // R3

    AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> bus_rdata == 8'hFF); // R4

    AST_LOCKED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && bus_wr && bus_addr) |=> ($stable(dev_base) && $stable(dev_active))); // R4

    AST_ID_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && idx_q == 8'h20) |=> $stable(chip_id)); // R8

    AST_IDE_BASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> $stable(dev_base[47:16])); // R6

endmodule

bind cfg_port_ctrl cfg_port_chk #(.NDEV(NDEV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .idx_q      (idx_q),
    .chip_id    (chip_id)
);

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;

    localparam int NDEV = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_addr = 1'b0;
    logic               bus_wr = 1'b0;
    logic [7:0]         bus_wdata = 8'h00;
    logic [7:0]         bus_rdata, rdata_b;
    logic               cfg_open, open_b;
    logic [NDEV-1:0]    dev_active, active_b;
    logic [NDEV*16-1:0] dev_base, base_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit rd_req = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    cfg_port_ctrl #(.NDEV(NDEV), .VARIANT_ID(8'h03)) i_cfg_port_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
        .dev_active(dev_active), .dev_base(dev_base)
    );

    cfg_port_ctrl #(.NDEV(NDEV), .VARIANT_ID(8'h02)) i_cfg_port_ctrl_b (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .cfg_open(open_b),
        .dev_active(active_b), .dev_base(base_b)
    );

    // Monitor: pops the expected read values and compares them
    always @(negedge clk) begin
        if (rd_req && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_req = 1'b1;
        @(negedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string t);
        wr(1'b0, idx);
        rd(1'b1, e, t);
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        wr(1'b0, idx);
        wr(1'b1, v);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset: locked; R4 reads give all ones
        chk(32'(cfg_open), 0, "R10 locked after reset");
        rd(1'b0, 8'hFF, "R4 index read locked");
        rd(1'b1, 8'hFF, "R4 data read locked");
        chk(32'(dev_base[15:0]), 32'h03F0, "R10 dev0 base default");
        chk(32'(dev_active[0]), 1, "R12 dev0 active default");

        // R4 locked data write ignored (index still 0, targets global 0)
        wr(1'b1, 8'h3C);

        // R2 interrupted key sequence
        wr(1'b0, 8'h55);
        wr(1'b0, 8'h12);
        wr(1'b0, 8'h55);
        chk(32'(cfg_open), 0, "R2 interrupted key stays locked");
        // R2 data write between key writes does not reset count
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h55);
        chk(32'(cfg_open), 1, "R2 second key opens");

        // R3 index readback
        wr(1'b0, 8'h24);
        rd(1'b0, 8'h24, "R3 index readback");
        rd(1'b1, 8'h04, "R10 global 0x24 default");
        rd_reg(8'h00, 8'h00, "R4 locked write left global 0 at zero");
        rd_reg(8'h03, 8'h03, "R10 global 0x03");
        rd_reg(8'h26, 8'hF0, "R10 global 0x26");
        rd_reg(8'h27, 8'h03, "R10 global 0x27");
        rd_reg(8'h21, 8'h01, "R8 revision");
        rd_reg(8'h20, 8'h03, "R8 chip id");
        chk(32'(rdata_b), 32'h02, "R8 variant chip id");

        // R8 read-only id and revision
        set_reg(8'h20, 8'h77);
        rd_reg(8'h20, 8'h03, "R8 id write dropped");
        set_reg(8'h21, 8'h55);
        rd_reg(8'h21, 8'h01, "R8 rev write dropped");

        // R5 global read/write
        set_reg(8'h22, 8'h5A);
        rd_reg(8'h22, 8'h5A, "R5 global write");

        // R10 device 0 defaults via R5 selector
        set_reg(8'h07, 8'h00);
        rd_reg(8'h30, 8'h01, "R10 dev0 activate");
        rd_reg(8'h60, 8'h03, "R10 dev0 base hi");
        rd_reg(8'h61, 8'hF0, "R10 dev0 base lo");
        rd_reg(8'h70, 8'h06, "R10 dev0 0x70");
        rd_reg(8'h74, 8'h02, "R10 dev0 0x74");
        rd_reg(8'hF0, 8'h0E, "R10 dev0 0xF0");
        rd_reg(8'hF2, 8'hFF, "R10 dev0 0xF2");

        // R12 base write reaches output
        set_reg(8'h60, 8'h01);
        chk(32'(dev_base[15:0]), 32'h01F0, "R12 dev0 base output");
        set_reg(8'h30, 8'h00);
        chk(32'(dev_active[0]), 0, "R12 dev0 activate output");

        // R7 dev0 0x70 and 0x74 dropped
        set_reg(8'h70, 8'h09);
        rd_reg(8'h70, 8'h06, "R7 dev0 0x70 write dropped");
        set_reg(8'h74, 8'h09);
        rd_reg(8'h74, 8'h02, "R7 dev0 0x74 write dropped");

        // R11 unbacked register
        set_reg(8'h62, 8'h44);
        rd_reg(8'h62, 8'h00, "R11 unbacked reads zero");

        // R6 device 1 blocked
        set_reg(8'h07, 8'h01);
        set_reg(8'h60, 8'h07);
        chk(32'(dev_base[31:16]), 32'h01F0, "R6 dev1 base unchanged");
        rd_reg(8'h60, 8'h01, "R6 dev1 readback");

        // R6 device 7 blocked
        set_reg(8'h07, 8'h07);
        set_reg(8'h30, 8'h00);
        chk(32'(dev_active[7]), 1, "R6 dev7 activate unchanged");

        // R6 device number out of range
        set_reg(8'h07, 8'h0C);
        rd_reg(8'h30, 8'h00, "R6 out of range reads zero");

        // R7 does not apply above device 3
        set_reg(8'h07, 8'h04);
        set_reg(8'h70, 8'h05);
        rd_reg(8'h70, 8'h05, "R7 dev4 0x70 writable");

        // R9 device 9 gate on chip id
        set_reg(8'h07, 8'h09);
        set_reg(8'h30, 8'h01);
        chk(32'(dev_active[9]), 1, "R9 dev9 write accepted for id 3");
        chk(32'(active_b[9]), 0, "R9 dev9 write dropped for id 2");

        // R12 device 8 base
        set_reg(8'h07, 8'h08);
        set_reg(8'h61, 8'h00);
        chk(32'(dev_base[143:128]), 32'h0000, "R12 dev8 base output");

        // R3 exit, then R4 locked data write has no effect
        wr(1'b0, 8'h60);
        wr(1'b0, 8'hAA);
        chk(32'(cfg_open), 0, "R3 exit key locks");
        rd(1'b1, 8'hFF, "R4 read after exit");
        wr(1'b1, 8'h33);
        chk(32'(dev_base[143:128]), 32'h0000, "R4 locked write ignored");

        // R1 re-enter: index kept, data port reads dev8 0x60
        wr(1'b0, 8'h55);
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h60, "R1 index port after re-entry");
        rd(1'b1, 8'h00, "R1 data port reads dev8 0x60");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule